// File: doc/BRIEF.md
# Potentiometer Wiper Register Bank

This block holds the register state behind four digital potentiometer wipers. There are four volatile wiper registers that set the wiper positions, and a bank of four levels of four stored registers that stand in for nonvolatile storage. A small status register selects one of two targets for slot accesses: the wiper registers directly, or the stored registers of one level. The analog array is not part of the block. Current wiper values are driven out on a flat bus.

A serial slave front end feeds the block byte-level events: a register address at the start of a transaction, write strobes with a data byte, read strobes, and a STOP event. Accesses to the stored registers have side effects on the wiper registers. A status write that selects stored access loads the whole selected level into the wipers. A stored-register write loads the written wiper and refreshes the other three from their row. A stored-register read copies the stored value into that wiper.

Stored writes are staged during the transaction and committed at STOP. They commit only when the write-enable input is high, and committing starts a programmable busy period. During the busy period every incoming event is ignored.

Top module: `pwb_top`

## Requirements
- R1: The address selects the register. Addresses 0, 1, 2 and 3 select wiper slots 0A, 1B, 1A and 0B. Slot `a` is driven on `wiper_vals[8a+7:8a]`. Address 7 is the status register. Writes to addresses 4 to 6 have no effect, and reads of those addresses return 00h.
- R2: The status register resets to 00h. Bit 0 = 1 selects stored access and bit 0 = 0 selects wiper access. Bits 2:1 give the level (0 to 3). Bits 7:3 are ignored on write and read back as 0.
- R3: A status write with bit 0 = 1 loads all four wiper registers from the four stored registers of the level in that byte. The new values show on `wiper_vals` in the cycle after the strobe.
- R4: With bit 0 = 0, a slot write loads only that slot's wiper register. No stored register and no other wiper changes.
- R5: With bit 0 = 1, a slot write sets that slot's wiper to the byte. Each other wiper takes the byte already staged for it in the same transaction, or otherwise its stored register at the selected level.
- R6: With bit 0 = 1, a slot read returns the stored register of the selected level and copies it into that slot's wiper. `rd_data` is valid in the cycle after `rd_stb`. With bit 0 = 0, a read returns the wiper register.
- R7: After each write or read at addresses 0 to 3, the address advances by one and wraps from 3 to 0. Bytes past the fourth overwrite earlier slots in order. At address 7 the address does not advance.
- R8: If `wp_ok` is low at STOP, staged stored bytes are discarded. The stored registers are then unchanged and `busy` stays low. The wiper side effects of R5 still apply.
- R9: A STOP with staged bytes and `wp_ok` high writes them into the level selected at STOP. `busy` is then high for exactly NV_CYCLES cycles, starting the cycle after STOP.
- R10: While `busy` is high, address loads, writes, reads and STOPs are all ignored.
- R11: After reset, all wiper and stored registers are 00h and `busy` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| addr_ld | input | 1 | Load register address (transaction start) |
| addr_in | input | 3 | Register address to load |
| wr_stb | input | 1 | Write data byte strobe (has priority over rd_stb) |
| wr_data | input | 8 | Write data byte |
| rd_stb | input | 1 | Read byte strobe |
| rd_data | output | 8 | Read data, valid the cycle after rd_stb |
| stop_evt | input | 1 | STOP event ending the transaction |
| wp_ok | input | 1 | High allows committing stored writes |
| busy | output | 1 | Stored-write cycle in progress |
| wiper_vals | output | 32 | Four wiper register values, slot 0 in the low byte |

## Verification
A wrong wiper register shows on `wiper_vals` in the cycle after the strobe that set it, so the bench compares all four bytes after every write, read and status access. A wrong stored register or staging entry stays hidden until it is read back in stored mode, or until a later status copy or row refresh moves it into a wiper. For that reason every level is read back slot by slot. A wrong address pointer shows on the next byte, which lands in the wrong slot or reads the wrong register. A wrong busy counter shows as a busy length other than NV_CYCLES, or as events taking effect during the busy window.

// File: rtl/pwb_pkg.sv
package pwb_pkg;
    localparam int DW     = 8;
    localparam int SLOTS  = 4;
    localparam int LEVELS = 4;
    localparam int AW     = 3;
    localparam int SLOT_W = $clog2(SLOTS);
    localparam int LVL_W  = $clog2(LEVELS);
    localparam int SW     = 1 + LVL_W;
    localparam logic [AW-1:0] STATUS_ADDR = 3'd7;

    typedef logic [SLOTS-1:0][DW-1:0]              row_t;
    typedef logic [LEVELS-1:0][SLOTS-1:0][DW-1:0]  bank_t;

    typedef struct packed {
        logic [SW-1:0]    status;
        row_t             wcr;
        bank_t            dr;
        row_t             stage;
        logic [SLOTS-1:0] stage_v;
        logic [DW-1:0]    rdata;
    } state_t;
endpackage

// File: rtl/pwb_addr_ptr.sv
module pwb_addr_ptr
    import pwb_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [AW-1:0] load_addr,
    input  logic          step,
    output logic [AW-1:0] ptr
);
    logic [AW-1:0] ptr_d, ptr_q;

    always_comb begin
        ptr_d = ptr_q;
        if (load) begin
            ptr_d = load_addr;
        end else if (step && (ptr_q < AW'(SLOTS))) begin
            ptr_d = (ptr_q == AW'(SLOTS - 1)) ? '0 : ptr_q + AW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ptr_q <= '0;
        else        ptr_q <= ptr_d;
    end

    assign ptr = ptr_q;

    // R7: last slot wraps to the first
    a_r7_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !load && ptr_q == AW'(SLOTS - 1)) |=> (ptr_q == '0));

    // R7: status address does not advance
    a_r7_status_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !load && ptr_q == STATUS_ADDR) |=> (ptr_q == STATUS_ADDR));
endmodule

// File: rtl/pwb_nv_timer.sv
module pwb_nv_timer #(
    parameter int CYCLES = 20
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic busy
);
    localparam int CNT_W = $clog2(CYCLES + 1);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (start)               cnt_d = CNT_W'(CYCLES);
        else if (cnt_q != '0)    cnt_d = cnt_q - CNT_W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign busy = (cnt_q != '0);

    // R9: a commit raises busy on the next cycle
    a_r9_busy_start: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> busy);
endmodule

// File: rtl/pwb_rd_mux.sv
module pwb_rd_mux
    import pwb_pkg::*;
(
    input  logic [AW-1:0] ptr,
    input  logic [SW-1:0] status,
    input  row_t          wcr,
    input  bank_t         dr,
    output logic [DW-1:0] rd_val
);
    logic [SLOT_W-1:0] slot;
    logic [LVL_W-1:0]  lvl;

    assign slot = ptr[SLOT_W-1:0];
    assign lvl  = status[SW-1:1];

    always_comb begin
        rd_val = '0;
        if (ptr == STATUS_ADDR) begin
            rd_val = DW'(status);
        end else if (ptr < AW'(SLOTS)) begin
            rd_val = status[0] ? dr[lvl][slot] : wcr[slot];
        end
    end
endmodule

// File: rtl/pwb_top.sv
module pwb_top
    import pwb_pkg::*;
#(
    parameter int NV_CYCLES = 20
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                addr_ld,
    input  logic [AW-1:0]       addr_in,
    input  logic                wr_stb,
    input  logic [DW-1:0]       wr_data,
    input  logic                rd_stb,
    output logic [DW-1:0]       rd_data,
    input  logic                stop_evt,
    input  logic                wp_ok,
    output logic                busy,
    output logic [SLOTS*DW-1:0] wiper_vals
);
    state_t s_d, s_q;

    logic [AW-1:0]     ptr;
    logic [DW-1:0]     rd_val;
    logic              acc_ok;
    logic              is_slot;
    logic [SLOT_W-1:0] slot;
    logic [LVL_W-1:0]  lvl;
    logic [LVL_W-1:0]  new_lvl;
    logic              commit;
    logic              step;

    assign acc_ok  = !busy;
    assign is_slot = (ptr < AW'(SLOTS));
    assign slot    = ptr[SLOT_W-1:0];
    assign lvl     = s_q.status[SW-1:1];
    assign new_lvl = wr_data[SW-1:1];
    assign commit  = acc_ok && stop_evt && (|s_q.stage_v) && wp_ok;
    assign step    = acc_ok && (wr_stb || rd_stb) && is_slot;

    pwb_addr_ptr u_ptr (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (acc_ok && addr_ld),
        .load_addr (addr_in),
        .step      (step),
        .ptr       (ptr)
    );

    pwb_nv_timer #(.CYCLES(NV_CYCLES)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .start (commit),
        .busy  (busy)
    );

    pwb_rd_mux u_mux (
        .ptr    (ptr),
        .status (s_q.status),
        .wcr    (s_q.wcr),
        .dr     (s_q.dr),
        .rd_val (rd_val)
    );

    always_comb begin
        s_d = s_q;
        if (acc_ok && wr_stb) begin
            if (ptr == STATUS_ADDR) begin
                s_d.status = wr_data[SW-1:0];
                if (wr_data[0]) begin
                    for (int j = 0; j < SLOTS; j++) begin
                        s_d.wcr[j] = s_q.dr[new_lvl][j];
                    end
                end
            end else if (is_slot) begin
                if (!s_q.status[0]) begin
                    s_d.wcr[slot] = wr_data;
                end else begin
                    for (int j = 0; j < SLOTS; j++) begin
                        s_d.wcr[j] = s_q.stage_v[j] ? s_q.stage[j] : s_q.dr[lvl][j];
                    end
                    s_d.wcr[slot]     = wr_data;
                    s_d.stage[slot]   = wr_data;
                    s_d.stage_v[slot] = 1'b1;
                end
            end
        end else if (acc_ok && rd_stb) begin
            s_d.rdata = rd_val;
            if (is_slot && s_q.status[0]) begin
                s_d.wcr[slot] = s_q.dr[lvl][slot];
            end
        end
        if (acc_ok && stop_evt) begin
            if (commit) begin
                for (int j = 0; j < SLOTS; j++) begin
                    if (s_q.stage_v[j]) s_d.dr[lvl][j] = s_q.stage[j];
                end
            end
            s_d.stage_v = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign rd_data    = s_q.rdata;
    assign wiper_vals = s_q.wcr;

    // R10: events during busy change nothing
    a_r10_busy_freeze: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> ($stable(wiper_vals) && $stable(s_q.dr) && $stable(s_q.status)));

    // R8: write-protected STOP leaves stored registers alone
    a_r8_wp_discard: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_evt && !wp_ok) |=> $stable(s_q.dr));

    // R4: wiper-mode slot write touches no stored register nor status
    a_r4_wcr_only: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && wr_stb && is_slot && !s_q.status[0]) |=> ($stable(s_q.dr) && $stable(s_q.status)));

    // R3: status copy lands on the wiper outputs
    a_r3_row_copy: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && wr_stb && ptr == STATUS_ADDR && wr_data[0])
            |=> (wiper_vals == $past(s_q.dr[new_lvl])));

    // R1: unused addresses read as zero
    a_r1_unused_read: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && rd_stb && !wr_stb && !is_slot && ptr != STATUS_ADDR) |=> (rd_data == '0));
endmodule

// File: tb/pwb_top_tb.sv
module pwb_top_tb;
    localparam int NV = 20;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       addr_ld = 1'b0;
    logic [2:0] addr_in = '0;
    logic       wr_stb = 1'b0;
    logic [7:0] wr_data = '0;
    logic       rd_stb = 1'b0;
    logic [7:0] rd_data;
    logic       stop_evt = 1'b0;
    logic       wp_ok = 1'b1;
    logic       busy;
    logic [31:0] wiper_vals;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    logic [2:0] m_ptr = '0;
    logic [2:0] m_status = '0;
    logic [7:0] m_wcr [4];
    logic [7:0] m_dr [4][4];
    logic [7:0] m_stg [4];
    bit         m_stv [4];

    always #5 clk = ~clk;

    pwb_top #(.NV_CYCLES(NV)) u_dut (
        .clk(clk), .rst_n(rst_n), .addr_ld(addr_ld), .addr_in(addr_in),
        .wr_stb(wr_stb), .wr_data(wr_data), .rd_stb(rd_stb), .rd_data(rd_data),
        .stop_evt(stop_evt), .wp_ok(wp_ok), .busy(busy), .wiper_vals(wiper_vals)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic chk_wipers(input string req);
        for (int i = 0; i < 4; i++) chk(req, 32'(wiper_vals[8*i +: 8]), 32'(m_wcr[i]));
    endtask

    task automatic op_addr(input logic [2:0] a, input bit mdl);
        @(negedge clk); addr_ld = 1'b1; addr_in = a;
        @(negedge clk); addr_ld = 1'b0;
        if (mdl) m_ptr = a;
    endtask

    task automatic op_wr(input logic [7:0] d, input bit mdl);
        @(negedge clk); wr_stb = 1'b1; wr_data = d;
        @(negedge clk); wr_stb = 1'b0;
        if (mdl) begin
            if (m_ptr == 3'd7) begin
                m_status = d[2:0];
                if (d[0]) for (int j = 0; j < 4; j++) m_wcr[j] = m_dr[d[2:1]][j];
            end else if (m_ptr < 3'd4) begin
                if (!m_status[0]) m_wcr[m_ptr[1:0]] = d;
                else begin
                    for (int j = 0; j < 4; j++) m_wcr[j] = m_stv[j] ? m_stg[j] : m_dr[m_status[2:1]][j];
                    m_wcr[m_ptr[1:0]] = d;
                    m_stg[m_ptr[1:0]] = d;
                    m_stv[m_ptr[1:0]] = 1'b1;
                end
                m_ptr = (m_ptr == 3'd3) ? 3'd0 : m_ptr + 3'd1;
            end
        end
    endtask

    task automatic op_rd(input string req);
        logic [7:0] e;
        e = 8'h00;
        if (m_ptr == 3'd7) e = {5'b0, m_status};
        else if (m_ptr < 3'd4) e = m_status[0] ? m_dr[m_status[2:1]][m_ptr[1:0]] : m_wcr[m_ptr[1:0]];
        @(negedge clk); rd_stb = 1'b1;
        @(negedge clk); rd_stb = 1'b0;
        chk(req, 32'(rd_data), 32'(e));
        if (m_ptr < 3'd4) begin
            if (m_status[0]) m_wcr[m_ptr[1:0]] = e;
            m_ptr = (m_ptr == 3'd3) ? 3'd0 : m_ptr + 3'd1;
        end
    endtask

    task automatic op_stop(input bit mdl);
        @(negedge clk); stop_evt = 1'b1;
        @(negedge clk); stop_evt = 1'b0;
        if (mdl) begin
            if (wp_ok) for (int j = 0; j < 4; j++) if (m_stv[j]) m_dr[m_status[2:1]][j] = m_stg[j];
            for (int j = 0; j < 4; j++) m_stv[j] = 1'b0;
        end
    endtask

    task automatic wait_idle(output int cnt);
        cnt = 0;
        while (busy && cnt < 1000) begin cnt++; @(negedge clk); end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=hung expected=finished");
        finish_run();
    end

    initial begin
        int bc;
        for (int i = 0; i < 4; i++) begin
            m_wcr[i] = '0; m_stg[i] = '0; m_stv[i] = 0;
            for (int l = 0; l < 4; l++) m_dr[l][i] = '0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R11 reset state
        chk("R11 wipers", wiper_vals, 32'h0);
        chk("R11 busy", 32'(busy), 32'h0);
        // R2 status reset, R7 no advance at status address
        op_addr(3'd7, 1);
        op_rd("R2 status reset");
        op_rd("R7 status hold");

        // R4 wiper mode page write with wrap (R7)
        op_wr(8'h00, 1);
        op_addr(3'd0, 1);
        for (int k = 0; k < 6; k++) begin
            op_wr(8'hA0 + 8'(k * 7), 1);
            chk_wipers("R4 R7 wiper write");
        end

        // R5/R9 stored page writes on every level
        for (int l = 0; l < 4; l++) begin
            op_addr(3'd7, 1);
            op_wr({5'b0, 2'(l), 1'b1}, 1);
            chk_wipers("R3 select level");
            op_addr(3'd0, 1);
            for (int k = 0; k < 4; k++) begin
                op_wr(8'h11 * 8'(l + 1) + 8'(k * 3), 1);
                chk_wipers("R5 stored write");
            end
            op_stop(1);
            chk("R9 busy rise", 32'(busy), 32'h1);
            wait_idle(bc);
            chk("R9 busy length", 32'(bc), 32'(NV));
        end

        // R3 row copy per level
        for (int l = 3; l >= 0; l--) begin
            op_addr(3'd7, 1);
            op_wr({5'b11010, 2'(l), 1'b1}, 1);
            chk_wipers("R3 row copy");
            op_rd("R2 reserved bits");
        end

        // R8 protected writes, R6 read copy
        wp_ok = 1'b0;
        for (int l = 0; l < 4; l++) begin
            op_addr(3'd7, 1);
            op_wr({5'b0, 2'(l), 1'b1}, 1);
            for (int s = 0; s < 4; s++) begin
                op_addr(3'(s), 1);
                op_wr(8'h5C ^ 8'(s * 17 + l), 1);
                chk_wipers("R8 wiper side effect");
                op_stop(1);
                chk("R8 no busy", 32'(busy), 32'h0);
                op_addr(3'(s), 1);
                op_rd("R6 R8 stored read");
                chk_wipers("R6 read copy");
            end
        end
        wp_ok = 1'b1;

        // R5/R7 partial page from address 2 at level 2
        op_addr(3'd7, 1);
        op_wr(8'h05, 1);
        op_addr(3'd2, 1);
        for (int k = 0; k < 3; k++) begin
            op_wr(8'hC1 + 8'(k), 1);
            chk_wipers("R5 partial page");
        end
        op_stop(1);
        wait_idle(bc);
        op_addr(3'd0, 1);
        for (int s = 0; s < 4; s++) op_rd("R5 R9 readback");

        // R1 unused address
        op_addr(3'd5, 1);
        op_wr(8'hFF, 1);
        chk_wipers("R1 unused write");
        op_rd("R1 unused read");

        // R10 events during busy
        op_addr(3'd7, 1);
        op_wr(8'h03, 1);
        op_addr(3'd0, 1);
        op_wr(8'h77, 1);
        op_stop(1);
        op_addr(3'd7, 0);
        op_wr(8'h00, 0);
        chk_wipers("R10 write ignored");
        chk("R10 still busy", 32'(busy), 32'h1);
        wait_idle(bc);
        op_rd("R10 address load ignored");
        op_addr(3'd7, 1);
        op_rd("R10 status kept");

        finish_run();
    end
endmodule